// File: doc/BRIEF.md
# PLL Programmable Divider Network

This block holds the digital clock dividers that sit around the oscillator of a phase-locked loop. A reference-side divider turns the incoming reference clock into the clock presented to the phase detector. An output-side divider turns the oscillator clock into the output clock, and a bypass can route the oscillator straight to the output instead. A third divider produces the clock fed back to the phase detector. That divider can run from either the raw oscillator clock or the final output clock.

All ratio and mode settings are sampled into shadow registers only while the power-down input is asserted. Once the block runs, its inputs may move freely without effect. To retune, system software asserts power-down, presents the new settings and releases power-down. The oscillator and the phase detector themselves are outside this block.

Top module: `pll_divnet`

## Requirements
- R1: The phase-detector reference clock `clk_pdref_o` has a period of `pre_ratio_m1_i + 1` reference cycles, where `pre_ratio_m1_i` is 2 bits wide (ratios 1 to 4).
- R2: The feedback clock `clk_fb_o` has a period of `fb_ratio_m1_i + 1` cycles of its source clock, where `fb_ratio_m1_i` is 8 bits wide (ratios 1 to 256).
- R3: With `bypass_i` captured as 0, `clk_out_o` has a period of 2, 4, 8 or 16 oscillator cycles for `post_code_i` = 0, 1, 2 or 3, and is high for exactly half of each period.
- R4: With `bypass_i` captured as 1, `clk_out_o` follows `clk_osc_i` directly, high while it is high and low while it is low.
- R5: With `fb_from_out_i` captured as 0, the feedback divider counts rising edges of `clk_osc_i`. With it captured as 1, the divider counts rising edges of `clk_out_o`.
- R6: All five settings are sampled only while `pwr_dn_n_i` is low. Changes to them while `pwr_dn_n_i` is high do not alter any output clock.
- R7: While `pwr_dn_n_i` is low, all three output clocks are low and every divider counter returns to its start state at its next clock edge.
- R8: For a ratio R > 1, a divider output is high after source edges 1 to floor(R/2) of each R-edge period and low after the rest, counting from the first edge after power-down is released. A ratio of 1 passes the source clock through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | Reference clock into the reference-side divider |
| clk_osc_i | input | 1 | Oscillator clock |
| pwr_dn_n_i | input | 1 | Low: power-down. Also acts as the synchronous active-low reset |
| pre_ratio_m1_i | input | 2 | Reference divide ratio minus one |
| fb_ratio_m1_i | input | 8 | Feedback divide ratio minus one |
| post_code_i | input | 2 | Output divide code, ratio = 2 << code |
| bypass_i | input | 1 | 1: oscillator drives the output directly |
| fb_from_out_i | input | 1 | 1: feedback divider runs from the output clock |
| clk_out_o | output | 1 | Output clock |
| clk_pdref_o | output | 1 | Divided reference toward the phase detector |
| clk_fb_o | output | 1 | Divided feedback clock |

## Verification
Each output clock is sampled just after every rising and falling edge of its source clock. The bench runs directed settings at the ratio extremes: 1, 4 and 256 for the fed-back and reference dividers, and codes 0 and 3 for the output divider. It then runs random setting combinations, so odd ratios are told apart from even ones and the pass-through case is told apart from the divided case. Running the feedback divider from the output clock in both bypass and divided modes checks that the source choice matters: the feedback period then scales with the output ratio. In the second half of each run the setting inputs are scrambled, which shows that nothing leaks through outside power-down.

// File: rtl/pll_divnet_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, types and helpers for the PLL divider network.
// Assumes: output divide ratio is a power of two selected by a small code.
package pll_divnet_pkg;

    localparam int PRE_SEL_W   = 2;
    localparam int FB_SEL_W    = 8;
    localparam int POST_CODE_W = 2;

    // Source choice for the feedback divider
    typedef enum logic {
        FB_FROM_OSC = 1'b0,
        FB_FROM_OUT = 1'b1
    } fb_src_e;

    // Output divide ratio minus one for a given power-of-two code
    function automatic logic [31:0] post_ratio_m1(input logic [31:0] code);
        return (32'd2 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/pll_clk_sel.sv
`timescale 1ns/1ps
// Module: pll_clk_sel
// Two-way clock selector with an enable that forces the output low.
// Assumes: the select and the enable change only while both inputs are low,
// so the selector never creates a short pulse.
module pll_clk_sel (
    input  logic en_i,
    input  logic sel_i,
    input  logic clk0_i,
    input  logic clk1_i,
    output logic clk_o
);

    // Pick one clock and gate it with the enable
    always_comb begin
        clk_o = en_i & (sel_i ? clk1_i : clk0_i);
    end

endmodule

// File: rtl/pll_clk_div.sv
`timescale 1ns/1ps
// Module: pll_clk_div
// Integer clock divider with a registered output. For ratio R = ratio_m1_i+1
// the output is high after the first floor(R/2) source edges of each period.
// When HAS_BYPASS is set, a ratio of one passes the source clock through.
// Assumes: ratio_m1_i is static while srst_n_i is high.
module pll_clk_div #(
    parameter int W          = 2,
    parameter bit HAS_BYPASS = 1'b1
) (
    input  logic         clk_i,
    input  logic         srst_n_i,
    input  logic [W-1:0] ratio_m1_i,
    output logic         clk_o,
    output logic [W-1:0] phase_o
);

    localparam int HW = W + 1;

    logic [W-1:0]  phase_q;
    logic          lvl_q;
    logic [HW-1:0] half_w;
    logic          at_end;

    // Number of high source cycles per period and end-of-period detect
    always_comb begin
        half_w = (HW'(ratio_m1_i) + HW'(1)) >> 1;
        at_end = (phase_q == ratio_m1_i);
    end

    // Phase counter and registered output level, cleared by the sync reset
    always_ff @(posedge clk_i) begin
        if (!srst_n_i) begin
            phase_q <= '0;
            lvl_q   <= 1'b0;
        end else begin
            lvl_q   <= (HW'(phase_q) < half_w);
            phase_q <= at_end ? '0 : phase_q + W'(1);
        end
    end

    generate
        if (HAS_BYPASS) begin : g_byp
            logic pass;
            // Ratio of one routes the source clock, otherwise the divided level
            always_comb begin
                pass  = (ratio_m1_i == '0);
                clk_o = srst_n_i & (pass ? clk_i : lvl_q);
            end
        end else begin : g_nobyp
            // Divided level only, gated low during reset
            always_comb begin
                clk_o = srst_n_i & lvl_q;
            end
        end
    endgenerate

    assign phase_o = phase_q;

endmodule

// File: rtl/pll_divnet.sv
`timescale 1ns/1ps
// Module: pll_divnet
// Divider network around a PLL oscillator: reference pre-divider, output
// post-divider with bypass, and feedback divider with selectable source.
// Assumes: pwr_dn_n_i changes while clk_osc_i and clk_ref_i are low; settings
// are shadowed while pwr_dn_n_i is low and ignored while it is high.
module pll_divnet #(
    parameter int PRE_W       = pll_divnet_pkg::PRE_SEL_W,
    parameter int FB_W        = pll_divnet_pkg::FB_SEL_W,
    parameter int POST_CODE_W = pll_divnet_pkg::POST_CODE_W
) (
    input  logic                   clk_ref_i,
    input  logic                   clk_osc_i,
    input  logic                   pwr_dn_n_i,
    input  logic [PRE_W-1:0]       pre_ratio_m1_i,
    input  logic [FB_W-1:0]        fb_ratio_m1_i,
    input  logic [POST_CODE_W-1:0] post_code_i,
    input  logic                   bypass_i,
    input  logic                   fb_from_out_i,
    output logic                   clk_out_o,
    output logic                   clk_pdref_o,
    output logic                   clk_fb_o
);

    import pll_divnet_pkg::*;

    localparam int POST_W = 1 << POST_CODE_W;

    logic [PRE_W-1:0]       pre_m1_q;
    logic [FB_W-1:0]        fb_m1_q;
    logic [POST_CODE_W-1:0] post_code_q;
    logic                   bypass_q;
    fb_src_e                fb_src_q;

    logic [POST_W-1:0]      post_m1;
    logic [PRE_W-1:0]       pre_phase;
    logic [FB_W-1:0]        fb_phase;
    logic [POST_W-1:0]      post_phase;
    logic                   post_clk;
    logic                   fb_src_clk;
    logic                   fb_sel_out;

    // Shadow the reference-side ratio while powered down
    always_ff @(posedge clk_ref_i) begin
        if (!pwr_dn_n_i) begin
            pre_m1_q <= pre_ratio_m1_i;
        end
    end

    // Shadow the oscillator-side settings while powered down
    always_ff @(posedge clk_osc_i) begin
        if (!pwr_dn_n_i) begin
            fb_m1_q     <= fb_ratio_m1_i;
            post_code_q <= post_code_i;
            bypass_q    <= bypass_i;
            fb_src_q    <= fb_src_e'(fb_from_out_i);
        end
    end

    // Decode the power-of-two code and the run-time feedback source
    always_comb begin
        post_m1    = POST_W'(post_ratio_m1(32'(post_code_q)));
        fb_sel_out = pwr_dn_n_i & (fb_src_q == FB_FROM_OUT);
    end

    pll_clk_div #(.W(PRE_W), .HAS_BYPASS(1'b1)) u_pre_div (
        .clk_i      (clk_ref_i),
        .srst_n_i   (pwr_dn_n_i),
        .ratio_m1_i (pre_m1_q),
        .clk_o      (clk_pdref_o),
        .phase_o    (pre_phase)
    );

    pll_clk_div #(.W(POST_W), .HAS_BYPASS(1'b0)) u_post_div (
        .clk_i      (clk_osc_i),
        .srst_n_i   (pwr_dn_n_i),
        .ratio_m1_i (post_m1),
        .clk_o      (post_clk),
        .phase_o    (post_phase)
    );

    pll_clk_sel u_out_sel (
        .en_i   (pwr_dn_n_i),
        .sel_i  (bypass_q),
        .clk0_i (post_clk),
        .clk1_i (clk_osc_i),
        .clk_o  (clk_out_o)
    );

    // During power-down the feedback divider runs from the oscillator so
    // that its synchronous reset always sees edges
    pll_clk_sel u_fb_sel (
        .en_i   (1'b1),
        .sel_i  (fb_sel_out),
        .clk0_i (clk_osc_i),
        .clk1_i (clk_out_o),
        .clk_o  (fb_src_clk)
    );

    pll_clk_div #(.W(FB_W), .HAS_BYPASS(1'b1)) u_fb_div (
        .clk_i      (fb_src_clk),
        .srst_n_i   (pwr_dn_n_i),
        .ratio_m1_i (fb_m1_q),
        .clk_o      (clk_fb_o),
        .phase_o    (fb_phase)
    );

endmodule

// File: rtl/pll_divnet_chk.sv
`timescale 1ns/1ps
// Module: pll_divnet_chk
// Property checker bound into pll_divnet. Observes shadow registers and
// divider phase counters across oscillator and reference edges.
// Assumes: power-down is asserted at the start of simulation.
module pll_divnet_chk #(
    parameter int PRE_W       = 2,
    parameter int FB_W        = 8,
    parameter int POST_CODE_W = 2,
    parameter int POST_W      = 4
) (
    input logic                   clk_osc_i,
    input logic                   clk_ref_i,
    input logic                   pwr_dn_n_i,
    input logic [PRE_W-1:0]       pre_m1_q,
    input logic [FB_W-1:0]        fb_m1_q,
    input logic [POST_CODE_W-1:0] post_code_q,
    input logic                   bypass_q,
    input logic                   fb_src_q,
    input logic [PRE_W-1:0]       pre_phase,
    input logic [FB_W-1:0]        fb_phase,
    input logic [POST_W-1:0]      post_phase
);

    AST_PD_CLEARS_POST: assert property (@(posedge clk_osc_i)
        !pwr_dn_n_i |=> (post_phase == '0)); // R7

    AST_PD_CLEARS_PRE: assert property (@(posedge clk_ref_i)
        !pwr_dn_n_i |=> (pre_phase == '0)); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk_osc_i) disable iff (!pwr_dn_n_i)
        $past(pwr_dn_n_i) |-> ($stable(fb_m1_q) && $stable(post_code_q) &&
                               $stable(bypass_q) && $stable(fb_src_q))); // R6

    AST_POST_ADVANCE: assert property (@(posedge clk_osc_i) disable iff (!pwr_dn_n_i)
        $past(pwr_dn_n_i) |-> (post_phase != $past(post_phase))); // R3

    AST_FB_OSC_ADVANCE: assert property (@(posedge clk_osc_i) disable iff (!pwr_dn_n_i)
        ($past(pwr_dn_n_i) && !fb_src_q && (fb_m1_q != '0)) |-> (fb_phase != $past(fb_phase))); // R5

    AST_FB_RANGE: assert property (@(posedge clk_osc_i) disable iff (!pwr_dn_n_i)
        fb_phase <= fb_m1_q); // R2

    AST_PRE_RANGE: assert property (@(posedge clk_ref_i) disable iff (!pwr_dn_n_i)
        pre_phase <= pre_m1_q); // R1

endmodule

bind pll_divnet pll_divnet_chk #(
    .PRE_W       (PRE_W),
    .FB_W        (FB_W),
    .POST_CODE_W (POST_CODE_W),
    .POST_W      (POST_W)
) u_chk (
    .clk_osc_i   (clk_osc_i),
    .clk_ref_i   (clk_ref_i),
    .pwr_dn_n_i  (pwr_dn_n_i),
    .pre_m1_q    (pre_m1_q),
    .fb_m1_q     (fb_m1_q),
    .post_code_q (post_code_q),
    .bypass_q    (bypass_q),
    .fb_src_q    (fb_src_q),
    .pre_phase   (pre_phase),
    .fb_phase    (fb_phase),
    .post_phase  (post_phase)
);

// File: tb/pll_divnet_bench.sv
`timescale 1ns/1ps
// Bench for pll_divnet: directed corners plus seeded random settings.
// Outputs are sampled 1 ns after every source clock edge and compared
// with levels computed from edge counts since power-down release.
module pll_divnet_bench;

    logic       clk_ref = 1'b0;
    logic       clk_osc = 1'b0;
    logic       pwr_dn_n = 1'b0;
    logic [1:0] pre_m1 = '0;
    logic [7:0] fb_m1 = '0;
    logic [1:0] post_code = '0;
    logic       byp = 1'b0;
    logic       fb_out = 1'b0;
    logic       clk_out, clk_pdref, clk_fb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    bit running = 1'b0;
    bit scramble = 1'b0;
    int e_pre_r, e_fb_r, e_post_r;
    bit e_byp, e_src;
    int k_osc, k_ref, k_fb;
    bit post_lvl, prev_post, fb_div_lvl, pre_lvl, out_exp;

    pll_divnet u_pll_divnet (
        .clk_ref_i      (clk_ref),
        .clk_osc_i      (clk_osc),
        .pwr_dn_n_i     (pwr_dn_n),
        .pre_ratio_m1_i (pre_m1),
        .fb_ratio_m1_i  (fb_m1),
        .post_code_i    (post_code),
        .bypass_i       (byp),
        .fb_from_out_i  (fb_out),
        .clk_out_o      (clk_out),
        .clk_pdref_o    (clk_pdref),
        .clk_fb_o       (clk_fb)
    );

    always #2 clk_osc = ~clk_osc;   // 250 MHz oscillator
    always #6 clk_ref = ~clk_ref;   // slower reference

    // Expected divider level after k source edges for ratio r (r > 1)
    function automatic bit div_exp(input int k, input int r);
        if (k == 0) return 1'b0;
        return ((k - 1) % r) < (r / 2);
    endfunction

    task automatic check(input string tag, input string name, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at %0t: got %0b expected %0b", tag, name, $time, act, exp);
        end
    endtask

    function automatic string tag_out();
        if (!running) return "R7";
        if (scramble) return "R6";
        return e_byp ? "R4" : "R3";
    endfunction

    function automatic string tag_fb();
        if (!running) return "R7";
        if (scramble) return "R6";
        if (e_fb_r == 1 || (e_fb_r % 2) == 1) return "R8";
        return e_src ? "R5" : "R2";
    endfunction

    function automatic string tag_pre();
        if (!running) return "R7";
        if (scramble) return "R6";
        if (e_pre_r == 1 || (e_pre_r % 2) == 1) return "R8";
        return "R1";
    endfunction

    // Oscillator-side checks just after each rising edge
    always @(posedge clk_osc) begin
        #1;
        if (!done) begin
            if (running) begin
                k_osc++;
                post_lvl = div_exp(k_osc, e_post_r);
                out_exp  = e_byp ? 1'b1 : post_lvl;
                if (!e_src || e_byp || (post_lvl && !prev_post)) k_fb++;
                prev_post = post_lvl;
                if (e_fb_r > 1) fb_div_lvl = div_exp(k_fb, e_fb_r);
                check(tag_out(), "clk_out rise", clk_out, out_exp);
                check(tag_fb(), "clk_fb rise", clk_fb,
                      (e_fb_r == 1) ? (e_src ? out_exp : 1'b1) : fb_div_lvl);
            end else begin
                check("R7", "clk_out pd", clk_out, 1'b0);
                check("R7", "clk_fb pd", clk_fb, 1'b0);
            end
        end
    end

    // Oscillator-side checks just after each falling edge
    always @(negedge clk_osc) begin
        #1;
        if (!done) begin
            if (running) begin
                out_exp = e_byp ? 1'b0 : post_lvl;
                check(tag_out(), "clk_out fall", clk_out, out_exp);
                check(tag_fb(), "clk_fb fall", clk_fb,
                      (e_fb_r == 1) ? (e_src ? out_exp : 1'b0) : fb_div_lvl);
            end else begin
                check("R7", "clk_out pd", clk_out, 1'b0);
                check("R7", "clk_fb pd", clk_fb, 1'b0);
            end
        end
    end

    // Reference-side checks just after each edge
    always @(clk_ref) begin
        #1;
        if (!done) begin
            if (running) begin
                if (clk_ref) begin
                    k_ref++;
                    if (e_pre_r > 1) pre_lvl = div_exp(k_ref, e_pre_r);
                end
                check(tag_pre(), "clk_pdref", clk_pdref, (e_pre_r == 1) ? clk_ref : pre_lvl);
            end else begin
                check("R7", "clk_pdref pd", clk_pdref, 1'b0);
            end
        end
    end

    // Step to a point where both clocks are low
    task automatic quiet_point();
        @(negedge clk_ref);
        #1.5;
    endtask

    // One configuration: power down, load, release, run, then scramble inputs
    task automatic run_cfg(input int pre, input int fb, input int code,
                           input bit b, input bit s, input int n_ref);
        quiet_point();
        pwr_dn_n = 1'b0;
        running  = 1'b0;
        scramble = 1'b0;
        pre_m1 = 2'(pre); fb_m1 = 8'(fb); post_code = 2'(code); byp = b; fb_out = s;
        repeat (3) quiet_point();
        e_pre_r = pre + 1; e_fb_r = fb + 1; e_post_r = 2 << code;
        e_byp = b; e_src = s;
        k_osc = 0; k_ref = 0; k_fb = 0;
        post_lvl = 0; prev_post = 0; fb_div_lvl = 0; pre_lvl = 0;
        pwr_dn_n = 1'b1;
        running  = 1'b1;
        repeat (n_ref / 2) quiet_point();
        scramble = 1'b1;
        for (int i = 0; i < n_ref - n_ref / 2; i++) begin
            quiet_point();
            pre_m1 = 2'($urandom); fb_m1 = 8'($urandom); post_code = 2'($urandom);
            byp = 1'($urandom); fb_out = 1'($urandom);
        end
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);
        // Reset state: all outputs low while powered down (R7)
        repeat (4) quiet_point();
        // Directed corners
        run_cfg(3, 255, 0, 1'b0, 1'b0, 400);  // R2 widest feedback ratio
        run_cfg(0, 0, 3, 1'b0, 1'b1, 60);     // R8 pass-through, R5 from output
        run_cfg(2, 4, 3, 1'b0, 1'b1, 120);    // R5 feedback from divided output
        run_cfg(1, 5, 1, 1'b1, 1'b1, 40);     // R4 bypass feeding feedback
        run_cfg(3, 2, 2, 1'b1, 1'b0, 40);     // R4 bypass, odd ratios
        // Random mix
        for (int t = 0; t < 24; t++) begin
            run_cfg(int'($urandom % 4), int'($urandom % 32), int'($urandom % 4),
                    1'($urandom), 1'($urandom), 150);
        end
        quiet_point();
        pwr_dn_n = 1'b0;
        running  = 1'b0;
        repeat (3) quiet_point();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule